// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Controller

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory with a small set of discrete control inputs. The inputs are an active-low chip enable, an active-low output enable, a flag that says the output-enable pin is at programming voltage, a flag that says address line 9 is at high voltage, and a flag that says the programming supply is present. From these inputs the block decodes one of seven operating modes. It returns array bytes or a two-byte identifier on a split data bus. It stores a byte only at the end of a proper programming pulse.

Cells can only move from 1 to 0 through programming. A synchronous erase input, which stands in for an optical wipe, returns every cell to 1. The array depth is set by a parameter. The full 64K-byte organisation is reached by setting the address width to 16. The default is smaller, so that elaboration stays light.

Top module: `otp_rom_ctrl`

## Requirements
- R1: After reset, and on the clock after `erase_i` is high, every address reads 0xFF. Erase takes priority over a write that completes in the same cycle.
- R2: With `ce_n_i`=0, `oe_n_i`=0, and `oe_hv_i`, `a9_hv_i` and `pgm_pwr_i` all 0, `mode_o` is 0 (read). `dq_oe_o` is 1, and `dq_o` shows the addressed byte in the same cycle.
- R3: With `ce_n_i`=1, `dq_oe_o` is 0 whatever the other inputs are. `mode_o` is 5 (inhibit) when `oe_hv_i`=1, and 2 (standby) otherwise.
- R4: With `ce_n_i`=0, `oe_hv_i`=0 and `oe_n_i`=1, `mode_o` is 1 (output off) and `dq_oe_o` is 0.
- R5: With `ce_n_i`=0 and `oe_hv_i`=1, `mode_o` is 3 (program) and `dq_oe_o` is 0. A pulse of one or more sampled low cycles writes `old AND dq_i` at `addr_i` exactly once. The write takes place on the clock at which `ce_n_i` is seen high again with `oe_hv_i` still 1, and uses the address and data of the last low cycle.
- R6: With `ce_n_i`=0, `oe_n_i`=0, `oe_hv_i`=0, `a9_hv_i`=0 and `pgm_pwr_i`=1, `mode_o` is 4 (verify), and the stored byte is driven as in read.
- R7: With `ce_n_i`=0, `oe_n_i`=0, `oe_hv_i`=0 and `a9_hv_i`=1, `mode_o` is 6 (identifier) regardless of `pgm_pwr_i`. `dq_o` is 0x97 when `addr_i[0]`=0 and 0x85 when it is 1, and `addr_i[9]` is ignored.
- R8: In identifier mode, any set address bit other than bits 0 and 9 makes `dq_o` 0x00.
- R9: The array is left unchanged by each of the following. A pulse with no sampled low cycle does not write. A pulse with `pgm_pwr_i`=0 in any low cycle does not write. A pulse that ends by dropping `oe_hv_i` instead of raising `ce_n_i` does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; also blanks the array |
| erase_i | input | 1 | Synchronous erase of all cells to 1 |
| ce_n_i | input | 1 | Chip enable, active low; also the programming pulse |
| oe_n_i | input | 1 | Output enable, active low |
| oe_hv_i | input | 1 | Output-enable pin held at programming voltage |
| a9_hv_i | input | 1 | Address line 9 held at high voltage (identifier mode) |
| pgm_pwr_i | input | 1 | Programming supply present |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data to program |
| dq_o | output | 8 | Data out (0 when not driving) |
| dq_oe_o | output | 1 | Data bus drive enable |
| mode_o | output | 3 | Decoded mode code |

## Verification
Mode, drive enable and read data are combinational from the inputs and the stored array. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and compares one nanosecond later. A programming pulse commits on the rising edge that first sees `ce_n_i` high. The bench therefore places one extra cycle between the end of a pulse and the read that checks it. Erase works the same way: it takes effect at the edge that samples `erase_i`, so the first check of the blanked array falls in the following cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_READ     = 3'd0,
        MODE_OFF      = 3'd1,
        MODE_STANDBY  = 3'd2,
        MODE_PROGRAM  = 3'd3,
        MODE_VERIFY   = 3'd4,
        MODE_INHIBIT  = 3'd5,
        MODE_IDCODE   = 3'd6
    } otp_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic oe_hv;
        logic a9_hv;
        logic pgm_pwr;
    } otp_ctl_t;

    localparam logic [7:0] ID_MAKER   = 8'h97;
    localparam logic [7:0] ID_PART    = 8'h85;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam int         ID_SEL_BIT = 0;
    localparam int         HV_BIT     = 9;

    function automatic logic mode_drives(otp_mode_e m);
        return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_IDCODE);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  otp_ctl_t  ctl_i,
    output otp_mode_e mode_o
);

    always_comb begin
        if (ctl_i.ce_n) begin
            mode_o = ctl_i.oe_hv ? MODE_INHIBIT : MODE_STANDBY;
        end else if (ctl_i.oe_hv) begin
            mode_o = MODE_PROGRAM;
        end else if (ctl_i.oe_n) begin
            mode_o = MODE_OFF;
        end else if (ctl_i.a9_hv) begin
            mode_o = MODE_IDCODE;
        end else if (ctl_i.pgm_pwr) begin
            mode_o = MODE_VERIFY;
        end else begin
            mode_o = MODE_READ;
        end
    end

    // a_r3_standby_mode: a high chip enable never yields a driving mode
    always_comb begin
        if (ctl_i.ce_n) begin
            a_r3_standby_mode: assert (!mode_drives(mode_o));
        end
    end

endmodule

// File: rtl/otp_pulse_ctrl.sv
module otp_pulse_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  otp_mode_e         mode_i,
    input  logic              pgm_pwr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    logic              in_prog_q;
    logic              armed_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            in_prog_q <= 1'b0;
            armed_q   <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else if (mode_i == MODE_PROGRAM) begin
            in_prog_q <= 1'b1;
            armed_q   <= pgm_pwr_i && (armed_q || !in_prog_q);
            addr_q    <= addr_i;
            data_q    <= din_i;
        end else begin
            in_prog_q <= 1'b0;
            armed_q   <= 1'b0;
        end
    end

    // The pulse ends properly only when chip enable rises with the high voltage still on
    assign wr_en_o   = in_prog_q && armed_q && (mode_i == MODE_INHIBIT);
    assign wr_addr_o = addr_q;
    assign wr_data_o = data_q;

    // a_r9_write_needs_pulse: a write only follows a cycle in program mode with supply
    a_r9_write_needs_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> ($past(mode_i) == MODE_PROGRAM) && $past(pgm_pwr_i));

    // a_r5_single_write: two writes never come back to back
    a_r5_single_write: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]       cell_q [DEPTH];
    logic [DEPTH-1:0] used_q;
    logic [7:0]       wr_old;
    logic             wr_ok;

    assign wr_ok     = wr_en_i && !erase_i && !rst_i;
    assign wr_old    = used_q[wr_addr_i] ? cell_q[wr_addr_i] : BLANK_BYTE;
    assign rd_data_o = used_q[rd_addr_i] ? cell_q[rd_addr_i] : BLANK_BYTE;

    always_ff @(posedge clk_i) begin
        if (rst_i || erase_i) begin
            used_q <= '0;
        end else if (wr_en_i) begin
            used_q[wr_addr_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_ok) begin
            cell_q[wr_addr_i] <= wr_old & wr_data_i;
        end
    end

    // a_r1_wipe_all: erase leaves no cell marked as programmed
    a_r1_wipe_all: assert property (@(posedge clk_i) disable iff (rst_i)
        erase_i |=> (used_q == '0));

    // a_r5_mark_written: a completed write marks its address
    a_r5_mark_written: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !erase_i) |=> used_q[$past(wr_addr_i)]);

endmodule

// File: rtl/otp_rom_ctrl.sv
module otp_rom_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              erase_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              oe_hv_i,
    input  logic              a9_hv_i,
    input  logic              pgm_pwr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe_o,
    output logic [2:0]        mode_o
);

    localparam logic [ADDR_W-1:0] ID_FREE_MASK =
        ~((ADDR_W'(1) << ID_SEL_BIT) | (ADDR_W'(1) << HV_BIT));

    otp_ctl_t          ctl;
    otp_mode_e         mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        arr_byte;
    logic [7:0]        id_byte;
    logic              drive;

    assign ctl = '{ce_n: ce_n_i, oe_n: oe_n_i, oe_hv: oe_hv_i,
                   a9_hv: a9_hv_i, pgm_pwr: pgm_pwr_i};

    otp_mode_decode u_decode (
        .ctl_i  (ctl),
        .mode_o (mode)
    );

    otp_pulse_ctrl #(.ADDR_W(ADDR_W)) u_pulse (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode),
        .pgm_pwr_i (pgm_pwr_i),
        .addr_i    (addr_i),
        .din_i     (dq_i),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .erase_i   (erase_i),
        .rd_addr_i (addr_i),
        .rd_data_o (arr_byte),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

    always_comb begin
        if ((addr_i & ID_FREE_MASK) != '0) begin
            id_byte = 8'h00;
        end else if (addr_i[ID_SEL_BIT]) begin
            id_byte = ID_PART;
        end else begin
            id_byte = ID_MAKER;
        end
    end

    assign drive   = mode_drives(mode);
    assign dq_oe_o = drive;
    assign mode_o  = mode;

    always_comb begin
        if (!drive) begin
            dq_o = 8'h00;
        end else if (mode == MODE_IDCODE) begin
            dq_o = id_byte;
        end else begin
            dq_o = arr_byte;
        end
    end

    // a_r3_float_when_deselected: chip enable high releases the bus
    a_r3_float_when_deselected: assert property (@(posedge clk_i) disable iff (rst_i)
        ce_n_i |-> !dq_oe_o);

    // a_r4_no_drive_at_vpp: the bus is never driven with the enable pin at programming voltage
    a_r4_no_drive_at_vpp: assert property (@(posedge clk_i) disable iff (rst_i)
        oe_hv_i |-> !dq_oe_o);

    // a_r7_id_maker: identifier mode, clean address, select low gives the maker byte
    a_r7_id_maker: assert property (@(posedge clk_i) disable iff (rst_i)
        (dq_oe_o && a9_hv_i && ((addr_i & ID_FREE_MASK) == '0) && !addr_i[ID_SEL_BIT])
        |-> (dq_o == 8'h97));

    // a_r8_id_dirty_zero: identifier mode with stray address bits gives zero
    a_r8_id_dirty_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (dq_oe_o && a9_hv_i && ((addr_i & ID_FREE_MASK) != '0)) |-> (dq_o == 8'h00));

endmodule

// File: tb/otp_rom_ctrl_tb.sv
module otp_rom_ctrl_tb;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst, erase, ce_n, oe_n, oe_hv, a9_hv, pwr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        din;
    logic [7:0]        dq_o;
    logic              dq_oe;
    logic [2:0]        mode;

    always #2 clk = ~clk;

    otp_rom_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk_i(clk), .rst_i(rst), .erase_i(erase), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .oe_hv_i(oe_hv), .a9_hv_i(a9_hv), .pgm_pwr_i(pwr), .addr_i(addr),
        .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe), .mode_o(mode)
    );

    typedef struct {
        string      req;
        logic [2:0] mode;
        logic       oe;
        logic [7:0] data;
        logic       chk_data;
    } exp_t;

    exp_t       sb[$];
    int         n_run  = 0;
    int         n_fail = 0;
    logic [7:0] model [DEPTH];
    bit         done   = 0;

    // monitor: compares one ns after the falling edge, when inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (mode !== e.mode || dq_oe !== e.oe || (e.chk_data && dq_o !== e.data)) begin
                    n_fail++;
                    $display("FAIL %s: mode=%0d oe=%0b data=%02h expected mode=%0d oe=%0b data=%02h",
                             e.req, mode, dq_oe, dq_o, e.mode, e.oe, e.data);
                end
            end
        end
    end

    task automatic drive(input logic c, input logic o, input logic hv, input logic a9,
                         input logic p, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; oe_hv = hv; a9_hv = a9; pwr = p; addr = a; din = d;
    endtask

    task automatic expect_out(input string r, input logic [2:0] m, input logic oe,
                              input logic [7:0] d);
        exp_t e;
        e.req = r; e.mode = m; e.oe = oe; e.data = d; e.chk_data = oe;
        sb.push_back(e);
    endtask

    task automatic read_chk(input string r, input logic [ADDR_W-1:0] a);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        expect_out(r, 3'd0, 1'b1, model[a]);
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 8'h00);
    endtask

    // program pulse: n low cycles, then chip enable rises with the high voltage held
    task automatic pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int n,
                         input logic p);
        for (int i = 0; i < n; i++) begin
            drive(1'b0, 1'b1, 1'b1, 1'b0, p, a, d);
            if (i == 0) expect_out("R5", 3'd3, 1'b0, 8'h00);
        end
        drive(1'b1, 1'b1, 1'b1, 1'b0, p, a, 8'h00);
        expect_out("R3", 3'd5, 1'b0, 8'h00);
        if (n > 0 && p) model[a] = model[a] & d;
        idle();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        rst = 1'b1; erase = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; pwr = 1'b0;
        addr = '0; din = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R3: standby after reset, with the output enable asserted too
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5, 8'h00);
        expect_out("R3", 3'd2, 1'b0, 8'h00);

        // R1 / R2: blank array reads all ones
        read_chk("R1", 11'd5);
        read_chk("R2", DEPTH - 1);

        // R5: program then AND-merge
        pulse(11'd5, 8'hA5, 2, 1'b1);
        read_chk("R5", 11'd5);
        pulse(11'd5, 8'h3C, 1, 1'b1);
        read_chk("R5", 11'd5);
        pulse(DEPTH - 1, 8'h0F, 3, 1'b1);
        read_chk("R5", DEPTH - 1);
        read_chk("R2", 11'd6);

        // R6: verify mode with the programming supply present
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'd5, 8'h00);
        expect_out("R6", 3'd4, 1'b1, 8'h24);

        // R4: output off
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd5, 8'h00);
        expect_out("R4", 3'd1, 1'b0, 8'h00);

        // R7: identifier bytes, bit 9 ignored, priority over verify
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'h000, 8'h00);
        expect_out("R7", 3'd6, 1'b1, 8'h97);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'h001, 8'h00);
        expect_out("R7", 3'd6, 1'b1, 8'h85);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'h201, 8'h00);
        expect_out("R7", 3'd6, 1'b1, 8'h85);

        // R8: stray address bits in identifier mode
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'h004, 8'h00);
        expect_out("R8", 3'd6, 1'b1, 8'h00);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'h401, 8'h00);
        expect_out("R8", 3'd6, 1'b1, 8'h00);

        // R9: no supply, supply dropped mid pulse, wrong ending, zero length
        pulse(11'd7, 8'h00, 2, 1'b0);
        read_chk("R9", 11'd7);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd8, 8'h00);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd8, 8'h00);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd8, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 11'd8, 8'h00);
        idle();
        read_chk("R9", 11'd8);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd9, 8'h00);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 11'd9, 8'h00);
        idle();
        read_chk("R9", 11'd9);
        pulse(11'd10, 8'h00, 0, 1'b1);
        read_chk("R9", 11'd10);

        // R1: erase wins over a write completing in the same cycle, then blanks all
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd11, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 11'd11, 8'h00);
        erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        read_chk("R1", 11'd5);
        read_chk("R1", DEPTH - 1);
        read_chk("R1", 11'd11);

        idle();
        idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule